// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides which pending exception a processor core takes and carries out the architectural state change that goes with it. It watches seven exception sources: a reset request, a data abort, a fast interrupt, a normal interrupt, a prefetch abort, an undefined-instruction trap and a software interrupt. It holds the current status word itself. The link registers and saved status words live in a banked register file outside the block. The block reaches that file through write strobes and a bank selector, and it tells the fetch stage where to go next through a PC load strobe.

An entry takes two cycles after acceptance. The first cycle writes the return address and the old status word into the bank of the new mode. The second cycle shows the updated status word together with a PC load of the exception vector. A return runs in a single step: the status word is reloaded from the saved copy and the PC is loaded with the return target in the same cycle. The reset request is the only source that does not wait for an instruction boundary, and it cuts off any sequence already in progress.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several sources are eligible in the same accepted cycle, only one is taken, in this order from highest to lowest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R2: Each source selects a mode code and a vector offset added to `VEC_BASE` (default 0). Reset gives 0x13 and 0x00. Undefined gives 0x1B and 0x04. Software interrupt gives 0x13 and 0x08. Prefetch abort gives 0x17 and 0x0C. Data abort gives 0x17 and 0x10. Normal interrupt gives 0x12 and 0x18. Fast interrupt gives 0x11 and 0x1C.
- R3: In the cycle after a non-reset exception is accepted, `lr_we` and `spsr_we` are both high. In that cycle `bank_mode` carries the new mode, `lr_wdata` carries `ret_addr` as it was in the accepting cycle, and `spsr_wdata` carries the old status word. In the cycle after that, `pc_we` is high with the vector address, and the save strobes are low.
- R4: On entry, status bits [4:0] become the new mode code, bit 5 (the compressed-instruction state) is cleared, bit 7 (normal interrupt mask) is set, and bits above 7 are kept.
- R5: Status bit 6 (fast interrupt mask) is set by fast interrupt and reset entries. Every other entry leaves it as it was.
- R6: Undefined, software interrupt, prefetch abort, data abort and both interrupts are accepted only in an idle cycle with `insn_done` high. Without `insn_done`, no strobe follows.
- R7: `req_reset` is accepted in any cycle, including during an entry or a return. It makes no save writes. The next cycle shows `pc_we` with vector 0x00 and status bits [7:0] equal to 0xD3 (mode 0x13, bits 7 and 6 set, bit 5 clear).
- R8: The normal interrupt level is eligible only while status bit 7 is clear, and the fast interrupt level only while bit 6 is clear. A level held while it is masked is taken at the first boundary after its mask clears.
- R9: An idle cycle with `eret_req` high (and no reset) takes priority over exceptions. In the next cycle, the status word equals `spsr_rdata` as it was in the request cycle, and `pc_we` is high with `eret_pc` in that same cycle. The status word changes in no cycle without `pc_we`.
- R10: After the asynchronous reset `rst_n`, the status word reads 0x000000D3 and no strobe is active.
- R11: While an entry or return is in progress, `insn_done`, exception requests other than reset, and `eret_req` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| insn_done | input | 1 | Current instruction completes this cycle (boundary) |
| req_reset | input | 1 | Reset exception request, taken at once |
| req_undef | input | 1 | Undefined-instruction trap of the completing instruction |
| req_swi | input | 1 | Software interrupt of the completing instruction |
| req_pabt | input | 1 | Prefetch abort of the completing instruction |
| req_dabt | input | 1 | Data abort of the completing instruction |
| irq_lvl | input | 1 | Normal interrupt level |
| fiq_lvl | input | 1 | Fast interrupt level |
| ret_addr | input | AW | Return address to save on entry |
| eret_req | input | 1 | Exception-return request |
| eret_pc | input | AW | PC target of the return |
| spsr_rdata | input | DW | Saved status word of the current mode from the register file |
| cpsr_o | output | DW | Current status word |
| lr_we | output | 1 | Link register write strobe |
| lr_wdata | output | AW | Link register write data |
| spsr_we | output | 1 | Saved status write strobe |
| spsr_wdata | output | DW | Saved status write data |
| bank_mode | output | 5 | Mode bank addressed by the save strobes |
| pc_we | output | 1 | PC load strobe |
| pc_next | output | AW | PC load value |

## Verification
The hardest case to reach is a masked interrupt level that has to survive until its mask is lifted. The mask can only change through a return, so the bench first returns into a status word with the mask set and holds the level across several boundaries. It then performs a return that clears the mask, with the level still held, and checks that the interrupt is taken at the next boundary. A reset request placed in the save cycle of an entry, and requests applied during the save and load cycles, are set up the same way to confirm that an active sequence is cut off by reset and ignores everything else.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

   // Ordered from highest to lowest priority; the arbiter relies on this.
   typedef enum logic [2:0] {
      CS_RESET = 3'd0,
      CS_DABT  = 3'd1,
      CS_FIQ   = 3'd2,
      CS_IRQ   = 3'd3,
      CS_PABT  = 3'd4,
      CS_UNDEF = 3'd5,
      CS_SWI   = 3'd6
   } exc_cause_e;

   localparam int NUM_CAUSE = 7;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_SAVE = 2'd1,
      SQ_LOAD = 2'd2
   } seq_state_e;

   localparam logic [4:0] MD_USR = 5'h10;
   localparam logic [4:0] MD_FIQ = 5'h11;
   localparam logic [4:0] MD_IRQ = 5'h12;
   localparam logic [4:0] MD_SVC = 5'h13;
   localparam logic [4:0] MD_ABT = 5'h17;
   localparam logic [4:0] MD_UND = 5'h1B;

   localparam int BIT_T = 5;
   localparam int BIT_F = 6;
   localparam int BIT_I = 7;
   localparam int PSR_CTL_W = 8;

   function automatic logic [4:0] cause_mode(exc_cause_e c);
      case (c)
         CS_RESET: return MD_SVC;
         CS_DABT:  return MD_ABT;
         CS_FIQ:   return MD_FIQ;
         CS_IRQ:   return MD_IRQ;
         CS_PABT:  return MD_ABT;
         CS_UNDEF: return MD_UND;
         default:  return MD_SVC;
      endcase
   endfunction

   function automatic logic [4:0] cause_offset(exc_cause_e c);
      case (c)
         CS_RESET: return 5'h00;
         CS_UNDEF: return 5'h04;
         CS_SWI:   return 5'h08;
         CS_PABT:  return 5'h0C;
         CS_DABT:  return 5'h10;
         CS_IRQ:   return 5'h18;
         default:  return 5'h1C;
      endcase
   endfunction

   function automatic logic masks_fast(exc_cause_e c);
      return (c == CS_RESET) || (c == CS_FIQ);
   endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
   import exc_ctrl_pkg::*;
#(
   parameter int N = NUM_CAUSE
) (
   input  logic [N-1:0] pend,
   output logic         any_pend,
   output exc_cause_e   win
);

   localparam int IDX_W = $clog2(N);

   if (N != NUM_CAUSE) begin : g_bad_n
      $error("exc_prio_arb: N must match the cause count");
   end

   assign any_pend = |pend;

   // Scan from the lowest priority upward so the last hit is the winner.
   always_comb begin
      win = CS_SWI;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) win = exc_cause_e'(IDX_W'(i));
      end
   end

endmodule

// File: rtl/exc_psr_build.sv
module exc_psr_build
   import exc_ctrl_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] cur,
   input  exc_cause_e    cause,
   output logic [DW-1:0] nxt
);

   logic [PSR_CTL_W-1:0] ctl;

   always_comb begin
      ctl         = cur[PSR_CTL_W-1:0];
      ctl[4:0]    = cause_mode(cause);
      ctl[BIT_T]  = 1'b0;
      ctl[BIT_F]  = cur[BIT_F] | masks_fast(cause);
      ctl[BIT_I]  = 1'b1;
   end

   assign nxt[PSR_CTL_W-1:0] = ctl;

   if (DW > PSR_CTL_W) begin : g_upper
      assign nxt[DW-1:PSR_CTL_W] = cur[DW-1:PSR_CTL_W];
   end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_ctrl_pkg::*;
#(
   parameter int               AW       = 32,
   parameter int               DW       = 32,
   parameter logic [AW-1:0]    VEC_BASE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          insn_done,
   input  logic          req_reset,
   input  logic          req_undef,
   input  logic          req_swi,
   input  logic          req_pabt,
   input  logic          req_dabt,
   input  logic          irq_lvl,
   input  logic          fiq_lvl,
   input  logic [AW-1:0] ret_addr,
   input  logic          eret_req,
   input  logic [AW-1:0] eret_pc,
   input  logic [DW-1:0] spsr_rdata,
   output logic [DW-1:0] cpsr_o,
   output logic          lr_we,
   output logic [AW-1:0] lr_wdata,
   output logic          spsr_we,
   output logic [DW-1:0] spsr_wdata,
   output logic [4:0]    bank_mode,
   output logic          pc_we,
   output logic [AW-1:0] pc_next
);

   localparam logic [DW-1:0] PSR_RST = DW'({1'b1, 1'b1, 1'b0, MD_SVC});

   if (AW < 6) begin : g_bad_aw
      $error("exc_entry_ctrl: AW must be at least 6");
   end
   if (DW < PSR_CTL_W) begin : g_bad_dw
      $error("exc_entry_ctrl: DW must hold the control byte");
   end
   if (VEC_BASE[4:0] != 5'd0) begin : g_bad_base
      $error("exc_entry_ctrl: VEC_BASE must be 32-byte aligned");
   end

   function automatic logic [AW-1:0] vec_of(exc_cause_e c);
      return VEC_BASE + AW'(cause_offset(c));
   endfunction

   seq_state_e    state_q;
   exc_cause_e    cause_q;
   logic [AW-1:0] ret_q;
   logic [DW-1:0] cpsr_q;
   logic [AW-1:0] pc_q;

   logic [NUM_CAUSE-1:0] elig;
   logic                 any_elig;
   exc_cause_e           arb_win;
   logic [DW-1:0]        psr_entry;
   logic [DW-1:0]        psr_reset;

   always_comb begin
      elig           = '0;
      elig[CS_RESET] = 1'b0;
      elig[CS_DABT]  = req_dabt;
      elig[CS_FIQ]   = fiq_lvl & ~cpsr_q[BIT_F];
      elig[CS_IRQ]   = irq_lvl & ~cpsr_q[BIT_I];
      elig[CS_PABT]  = req_pabt;
      elig[CS_UNDEF] = req_undef;
      elig[CS_SWI]   = req_swi;
   end

   exc_prio_arb #(.N(NUM_CAUSE)) arb_i (
      .pend     (elig),
      .any_pend (any_elig),
      .win      (arb_win)
   );

   exc_psr_build #(.DW(DW)) entry_psr_i (
      .cur   (cpsr_q),
      .cause (cause_q),
      .nxt   (psr_entry)
   );

   exc_psr_build #(.DW(DW)) reset_psr_i (
      .cur   (cpsr_q),
      .cause (CS_RESET),
      .nxt   (psr_reset)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cause_q <= CS_RESET;
         ret_q   <= '0;
         cpsr_q  <= PSR_RST;
         pc_q    <= '0;
      end else if (req_reset) begin
         cpsr_q  <= psr_reset;
         pc_q    <= vec_of(CS_RESET);
         cause_q <= CS_RESET;
         state_q <= SQ_LOAD;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (eret_req) begin
                  cpsr_q  <= spsr_rdata;
                  pc_q    <= eret_pc;
                  state_q <= SQ_LOAD;
               end else if (insn_done && any_elig) begin
                  cause_q <= arb_win;
                  ret_q   <= ret_addr;
                  state_q <= SQ_SAVE;
               end
            end
            SQ_SAVE: begin
               cpsr_q  <= psr_entry;
               pc_q    <= vec_of(cause_q);
               state_q <= SQ_LOAD;
            end
            default: begin
               state_q <= SQ_IDLE;
            end
         endcase
      end
   end

   assign cpsr_o     = cpsr_q;
   assign lr_we      = (state_q == SQ_SAVE);
   assign spsr_we    = (state_q == SQ_SAVE);
   assign lr_wdata   = ret_q;
   assign spsr_wdata = cpsr_q;
   assign bank_mode  = cause_mode(cause_q);
   assign pc_we      = (state_q == SQ_LOAD);
   assign pc_next    = pc_q;

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
   import exc_ctrl_pkg::*;
#(
   parameter int            AW       = 32,
   parameter int            DW       = 32,
   parameter logic [AW-1:0] VEC_BASE = '0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          insn_done,
   input logic          req_reset,
   input logic          eret_req,
   input logic [DW-1:0] cpsr_o,
   input logic          lr_we,
   input logic          spsr_we,
   input logic [DW-1:0] spsr_wdata,
   input logic [4:0]    bank_mode,
   input logic          pc_we,
   input logic [AW-1:0] pc_next
);

   // R3
   save_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |=> pc_we && !lr_we && !spsr_we);

   // R4
   entry_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spsr_we && !req_reset |=> cpsr_o[4:0] == $past(bank_mode) && cpsr_o[BIT_I] && !cpsr_o[BIT_T]);

   // R5
   fast_mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spsr_we && bank_mode == MD_FIQ |=> cpsr_o[BIT_F]);

   // R5
   fast_mask_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spsr_we && !req_reset && bank_mode != MD_FIQ |=> cpsr_o[BIT_F] == $past(spsr_wdata[BIT_F]));

   // R7
   reset_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_reset |=> pc_we && pc_next == VEC_BASE && !lr_we && cpsr_o[7:0] == 8'hD3);

   // R9
   status_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpsr_o != $past(cpsr_o) |-> pc_we);

   // R6
   boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_done && !req_reset && !eret_req && !lr_we && !pc_we |=> !lr_we && !pc_we);

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.AW(AW), .DW(DW), .VEC_BASE(VEC_BASE)) chk_i (.*);

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_done = 1'b0;
   logic        req_reset = 1'b0;
   logic        req_undef = 1'b0;
   logic        req_swi = 1'b0;
   logic        req_pabt = 1'b0;
   logic        req_dabt = 1'b0;
   logic        irq_lvl = 1'b0;
   logic        fiq_lvl = 1'b0;
   logic [31:0] ret_addr = '0;
   logic        eret_req = 1'b0;
   logic [31:0] eret_pc = '0;
   logic [31:0] spsr_rdata = '0;
   logic [31:0] cpsr_o;
   logic        lr_we;
   logic [31:0] lr_wdata;
   logic        spsr_we;
   logic [31:0] spsr_wdata;
   logic [4:0]  bank_mode;
   logic        pc_we;
   logic [31:0] pc_next;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   exc_entry_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .req_reset(req_reset),
      .req_undef(req_undef), .req_swi(req_swi), .req_pabt(req_pabt), .req_dabt(req_dabt),
      .irq_lvl(irq_lvl), .fiq_lvl(fiq_lvl), .ret_addr(ret_addr), .eret_req(eret_req),
      .eret_pc(eret_pc), .spsr_rdata(spsr_rdata), .cpsr_o(cpsr_o), .lr_we(lr_we),
      .lr_wdata(lr_wdata), .spsr_we(spsr_we), .spsr_wdata(spsr_wdata),
      .bank_mode(bank_mode), .pc_we(pc_we), .pc_next(pc_next)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic clear_reqs();
      insn_done = 0; req_undef = 0; req_swi = 0; req_pabt = 0; req_dabt = 0;
      irq_lvl = 0; fiq_lvl = 0; req_reset = 0; eret_req = 0;
   endtask

   // R9: return reloads status and PC in the same cycle
   task automatic do_ret(logic [31:0] psr, logic [31:0] pc);
      eret_req = 1; spsr_rdata = psr; eret_pc = pc;
      step();
      eret_req = 0; spsr_rdata = 32'hDEAD_BEEF;
      chk("R9 status restored", cpsr_o, psr);
      chk("R9 pc strobe with status", {31'd0, pc_we}, 32'd1);
      chk("R9 pc target", pc_next, pc);
      chk("R9 no save strobe", {31'd0, lr_we}, 32'd0);
      step();
   endtask

   // R3 R4 R5 R2: entry with requests already applied by the caller
   task automatic do_entry(string tag, logic [31:0] ra, logic [4:0] mode,
                           logic [31:0] off, bit fset);
      logic [31:0] old;
      logic [31:0] expv;
      old = cpsr_o;
      insn_done = 1; ret_addr = ra;
      step();
      clear_reqs();
      ret_addr = 32'h0BAD_0BAD;
      chk({tag, " R3 lr strobe"}, {31'd0, lr_we}, 32'd1);
      chk({tag, " R3 spsr strobe"}, {31'd0, spsr_we}, 32'd1);
      chk({tag, " R2 bank mode"}, {27'd0, bank_mode}, {27'd0, mode});
      chk({tag, " R3 lr data"}, lr_wdata, ra);
      chk({tag, " R3 spsr data"}, spsr_wdata, old);
      chk({tag, " R3 no early pc"}, {31'd0, pc_we}, 32'd0);
      step();
      expv = (old & 32'hFFFF_FF00) | 32'h80 | (fset ? 32'h40 : (old & 32'h40)) | {27'd0, mode};
      chk({tag, " R3 pc strobe"}, {31'd0, pc_we}, 32'd1);
      chk({tag, " R2 vector"}, pc_next, off);
      chk({tag, " R4 R5 status"}, cpsr_o, expv);
      chk({tag, " R3 save strobes off"}, {31'd0, lr_we | spsr_we}, 32'd0);
      step();
   endtask

   task automatic t_reset_state();
      chk("R10 status after reset", cpsr_o, 32'h0000_00D3);
      chk("R10 strobes idle", {29'd0, lr_we, spsr_we, pc_we}, 32'd0);
   endtask

   task automatic t_no_boundary();
      req_swi = 1; req_dabt = 1;
      step();
      chk("R6 no entry without boundary", {30'd0, lr_we, pc_we}, 32'd0);
      step();
      chk("R6 still idle", {30'd0, lr_we, pc_we}, 32'd0);
      clear_reqs();
   endtask

   task automatic t_priority();
      do_ret(32'h10, 32'h2000);
      req_dabt = 1; fiq_lvl = 1; irq_lvl = 1; req_pabt = 1; req_undef = 1;
      do_entry("R1 dabt wins", 32'h2004, 5'h17, 32'h10, 0);
      do_ret(32'h10, 32'h2100);
      fiq_lvl = 1; irq_lvl = 1; req_pabt = 1; req_swi = 1;
      do_entry("R1 fiq wins", 32'h2104, 5'h11, 32'h1C, 1);
      do_ret(32'h10, 32'h2200);
      irq_lvl = 1; req_pabt = 1; req_undef = 1;
      do_entry("R1 irq wins", 32'h2204, 5'h12, 32'h18, 0);
      do_ret(32'h10, 32'h2300);
      req_pabt = 1; req_undef = 1;
      do_entry("R1 pabt wins", 32'h2304, 5'h17, 32'h0C, 0);
      do_ret(32'h10, 32'h2400);
      req_undef = 1; req_swi = 1;
      do_entry("R1 undef over swi", 32'h2404, 5'h1B, 32'h04, 0);
   endtask

   task automatic t_thumb_clear();
      do_ret(32'hA000_0030, 32'h3000);
      req_swi = 1;
      do_entry("R4 thumb cleared swi", 32'h3002, 5'h13, 32'h08, 0);
   endtask

   task automatic t_masking();
      do_ret(32'h90, 32'h4000);
      irq_lvl = 1; insn_done = 1;
      step();
      chk("R8 masked irq not taken", {30'd0, lr_we, pc_we}, 32'd0);
      step();
      chk("R8 masked irq stays off", {30'd0, lr_we, pc_we}, 32'd0);
      insn_done = 0;
      do_ret(32'h10, 32'h4100);
      do_entry("R8 pending irq taken after unmask", 32'h4104, 5'h12, 32'h18, 0);
      do_ret(32'h50, 32'h4200);
      fiq_lvl = 1; irq_lvl = 1;
      do_entry("R8 fiq masked irq taken", 32'h4204, 5'h12, 32'h18, 0);
   endtask

   task automatic t_busy_ignore();
      do_ret(32'h10, 32'h5000);
      req_swi = 1; insn_done = 1; ret_addr = 32'h5004;
      step();
      req_swi = 0; req_undef = 1; eret_req = 1; eret_pc = 32'h7777;
      step();
      chk("R11 vector unaffected", pc_next, 32'h08);
      chk("R11 status unaffected", cpsr_o, 32'h93);
      step();
      clear_reqs();
      chk("R11 no second entry", {30'd0, lr_we, pc_we}, 32'd0);
      step();
   endtask

   task automatic t_reset_req();
      do_ret(32'h10, 32'h6000);
      req_swi = 1; insn_done = 1; ret_addr = 32'h6004;
      step();
      clear_reqs();
      chk("R7 save cycle reached", {31'd0, lr_we}, 32'd1);
      req_reset = 1;
      step();
      req_reset = 0;
      chk("R7 reset vector", pc_next, 32'h0);
      chk("R7 reset pc strobe", {31'd0, pc_we}, 32'd1);
      chk("R7 reset status", cpsr_o, 32'hD3);
      chk("R7 no save on reset", {31'd0, lr_we}, 32'd0);
      step();
      do_ret(32'h10, 32'h6100);
      req_reset = 1;
      step();
      req_reset = 0;
      chk("R7 idle reset pc strobe", {31'd0, pc_we}, 32'd1);
      chk("R7 idle reset status", cpsr_o, 32'hD3);
      step();
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset_state();
      do_ret(32'h10, 32'h1000);
      t_no_boundary();
      t_priority();
      t_thumb_clear();
      t_masking();
      t_busy_ignore();
      t_reset_req();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule